// File: doc/BRIEF.md
# Floating-Point Stack Conditional Move Unit

This unit carries out the conditional register-to-register move group of a stack-organised floating-point register file. An instruction arrives as two bytes, a prefix byte and an operand byte. The unit decodes from them a condition and a stack-relative source index i, and tests that condition against the integer carry, zero and parity flags. When the condition holds, the unit copies stack register ST(i) into ST(0). The stack is addressed relative to a top-of-stack pointer, and each physical register carries an empty/valid tag. The integer flags are only read.

Each instruction takes one cycle. The unit pulses `done` one cycle after `in_valid`, together with at most one of three fault indications: a stack underflow, a device-not-available fault, or an illegal opcode. It also keeps a C1 status bit. A load port writes physical registers and marks them valid. A control write sets the stack pointer and C1. A combinational read port shows any physical register and its tag. Together these let the surrounding pipeline fill and inspect the stack.

Top module: `fstk_cmov_unit`

## Requirements
- R1: After synchronous active-low reset all eight tags read empty, `top_ptr` is 0, `c1_flag` is 0, and `done`, `moved` and all three fault outputs are low.
- R2: With prefix byte 0xDA, operand-byte bits [4:3] select the move condition: 0 carry set, 1 zero set, 2 carry or zero set, 3 parity set.
- R3: With prefix byte 0xDB, the same field selects the inverse condition: 0 carry clear, 1 zero clear, 2 carry and zero both clear, 3 parity clear.
- R4: The destination is physical register `top_ptr`. The source is physical register (`top_ptr` + i) mod 8, with i taken from operand-byte bits [2:0]. An instruction never changes `top_ptr`.
- R5: When the condition is false, ST(0) keeps its data and tag, `moved` stays low and `done` still pulses. A successful move copies the data and marks the destination tag valid.
- R6: Underflow is an empty ST(0) tag, or a true condition with an empty ST(i) tag. It pulses `fault_stack`, clears `c1_flag` and writes nothing. A false condition with an empty ST(i) raises no fault.
- R7: If `ctl_em` or `ctl_ts` is high, the instruction does nothing. It pulses `fault_nodev`, and neither underflow nor illegal opcode is reported.
- R8: A prefix byte other than 0xDA/0xDB, or an operand byte outside 0xC0..0xDF, pulses `bad_opcode` and leaves every register, tag and `c1_flag` unchanged.
- R9: `done` is high for exactly the one cycle after each cycle with `in_valid` high. `moved` and the faults are valid only in that cycle, and at most one fault is high.
- R10: When a load and an instruction fall in the same cycle, the instruction sees the tags and data from before the load. If both write the same physical register, the move's data wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| op_hi | input | 8 | Prefix byte |
| op_lo | input | 8 | Operand byte |
| flag_cf | input | 1 | Integer carry flag |
| flag_zf | input | 1 | Integer zero flag |
| flag_pf | input | 1 | Integer parity flag |
| ctl_em | input | 1 | Emulation control bit (blocks execution) |
| ctl_ts | input | 1 | Task-switched control bit (blocks execution) |
| ld_en | input | 1 | Load a physical register and mark it valid |
| ld_slot | input | 3 | Physical register to load |
| ld_data | input | 80 | Load data |
| ctl_wr | input | 1 | Write stack pointer and C1 |
| ctl_top | input | 3 | New stack pointer |
| ctl_c1 | input | 1 | New C1 value |
| rd_slot | input | 3 | Physical register to inspect |
| rd_data | output | 80 | Data of `rd_slot` |
| rd_tag | output | 1 | Valid tag of `rd_slot` |
| top_ptr | output | 3 | Stack pointer |
| c1_flag | output | 1 | C1 status bit |
| done | output | 1 | Instruction completed (one-cycle pulse) |
| moved | output | 1 | Data was copied |
| fault_stack | output | 1 | Stack underflow pulse |
| fault_nodev | output | 1 | Device-not-available pulse |
| bad_opcode | output | 1 | Illegal opcode pulse |

## Verification
A load on the register port and an instruction can land in the same cycle. The two interact only when the load targets the move's destination or one of the registers whose tags the instruction checks. The bench provokes this with directed cases in which a load writes ST(0) during a successful move, and in which a load fills an empty ST(i) during an instruction whose condition is true. It also adds random loads to random instructions. Each outcome is judged against a model that applies the instruction to the state from before the load, and then applies the load only where the move did not write.

// File: rtl/fcm_pkg.sv
// Shared constants and types for the floating-point stack conditional move unit.
// Assumes an eight-deep stack of power-of-two depth so index arithmetic wraps.
package fcm_pkg;
    localparam int STACK_DEPTH = 8;
    localparam int REG_WIDTH   = 80;
    localparam int IDX_W       = $clog2(STACK_DEPTH);

    localparam logic [7:0] PFX_DIRECT = 8'hDA;
    localparam logic [7:0] PFX_INVERT = 8'hDB;
    localparam logic [2:0] OPND_HIGH  = 3'b110;

    typedef enum logic [1:0] {
        COND_CARRY  = 2'd0,
        COND_ZERO   = 2'd1,
        COND_CZ     = 2'd2,
        COND_PARITY = 2'd3
    } cond_sel_t;
endpackage

// File: rtl/fcm_decode.sv
// Opcode decoder: checks the two-byte encoding, extracts the condition field,
// the inversion bit and the stack-relative source index. Purely combinational.
module fcm_decode
    import fcm_pkg::*;
(
    input  logic [7:0]       op_hi,
    input  logic [7:0]       op_lo,
    output logic             legal,
    output logic             invert,
    output cond_sel_t        csel,
    output logic [IDX_W-1:0] src_idx
);
    // Field extraction and legality of the prefix and operand bytes.
    always_comb begin
        legal   = ((op_hi == PFX_DIRECT) || (op_hi == PFX_INVERT)) &&
                  (op_lo[7:5] == OPND_HIGH);
        invert  = (op_hi == PFX_INVERT);
        csel    = cond_sel_t'(op_lo[4:3]);
        src_idx = op_lo[IDX_W-1:0];
    end
endmodule

// File: rtl/fcm_cond_eval.sv
// Condition evaluator: tests the selected predicate on the integer flags and
// optionally inverts it. Flags are only read.
module fcm_cond_eval
    import fcm_pkg::*;
(
    input  cond_sel_t csel,
    input  logic      invert,
    input  logic      cf,
    input  logic      zf,
    input  logic      pf,
    output logic      cond_true
);
    logic base;

    // Select the raw predicate, then apply the inversion.
    always_comb begin
        unique case (csel)
            COND_CARRY:  base = cf;
            COND_ZERO:   base = zf;
            COND_CZ:     base = cf | zf;
            default:     base = pf;
        endcase
        cond_true = base ^ invert;
    end
endmodule

// File: rtl/fcm_regfile.sv
// Stack register storage with per-register valid tags. One move port
// (register-to-register, priority) and one load port. Reads use pre-edge state.
// Assumes DEPTH is a power of two.
module fcm_regfile #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 80,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mv_en,
    input  logic [IW-1:0]    mv_dst,
    input  logic [IW-1:0]    mv_src,
    input  logic             ld_en,
    input  logic [IW-1:0]    ld_slot,
    input  logic [WIDTH-1:0] ld_data,
    input  logic [IW-1:0]    rd_slot,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_tag,
    output logic [DEPTH-1:0] tags
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] mv_data;

    assign mv_data = mem[mv_src];

    // Data write: a move into an entry overrides a load to the same entry.
    always_ff @(posedge clk) begin
        for (int k = 0; k < DEPTH; k++) begin
            if (mv_en && (mv_dst == IW'(k)))
                mem[k] <= mv_data;
            else if (ld_en && (ld_slot == IW'(k)))
                mem[k] <= ld_data;
        end
    end

    // Tag update: reset to empty, either write port marks its entry valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tags <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if ((mv_en && (mv_dst == IW'(k))) || (ld_en && (ld_slot == IW'(k))))
                    tags[k] <= 1'b1;
            end
        end
    end

    // Inspection read port.
    always_comb begin
        rd_data = mem[rd_slot];
        rd_tag  = tags[rd_slot];
    end

    // R5: a move writes only from a source that was valid.
    a_r5_move_src_valid: assert property (@(posedge clk) disable iff (!rst_n)
        mv_en |-> tags[mv_src]);
endmodule

// File: rtl/fstk_cmov_unit.sv
// Floating-point stack conditional move unit (top). Decodes a two-byte
// instruction, tests the integer flags, checks stack tags and copies ST(i) to
// ST(0) when the condition holds. Results are registered: one cycle latency.
// Assumes flags and control bits are stable in the in_valid cycle.
module fstk_cmov_unit
    import fcm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           op_hi,
    input  logic [7:0]           op_lo,
    input  logic                 flag_cf,
    input  logic                 flag_zf,
    input  logic                 flag_pf,
    input  logic                 ctl_em,
    input  logic                 ctl_ts,
    input  logic                 ld_en,
    input  logic [IDX_W-1:0]     ld_slot,
    input  logic [REG_WIDTH-1:0] ld_data,
    input  logic                 ctl_wr,
    input  logic [IDX_W-1:0]     ctl_top,
    input  logic                 ctl_c1,
    input  logic [IDX_W-1:0]     rd_slot,
    output logic [REG_WIDTH-1:0] rd_data,
    output logic                 rd_tag,
    output logic [IDX_W-1:0]     top_ptr,
    output logic                 c1_flag,
    output logic                 done,
    output logic                 moved,
    output logic                 fault_stack,
    output logic                 fault_nodev,
    output logic                 bad_opcode
);
    logic                   legal, invert, cond_true;
    cond_sel_t              csel;
    logic [IDX_W-1:0]       src_idx, dst_phys, src_phys;
    logic [STACK_DEPTH-1:0] tags;
    logic                   blocked, exec, underflow, do_move;

    fcm_decode u_decode (
        .op_hi   (op_hi),
        .op_lo   (op_lo),
        .legal   (legal),
        .invert  (invert),
        .csel    (csel),
        .src_idx (src_idx)
    );

    fcm_cond_eval u_cond (
        .csel      (csel),
        .invert    (invert),
        .cf        (flag_cf),
        .zf        (flag_zf),
        .pf        (flag_pf),
        .cond_true (cond_true)
    );

    // Stack-relative to physical mapping and outcome classification.
    always_comb begin
        dst_phys  = top_ptr;
        src_phys  = top_ptr + src_idx;
        blocked   = ctl_em | ctl_ts;
        exec      = in_valid & ~blocked & legal;
        underflow = exec & (~tags[dst_phys] | (cond_true & ~tags[src_phys]));
        do_move   = exec & ~underflow & cond_true;
    end

    fcm_regfile #(.DEPTH(STACK_DEPTH), .WIDTH(REG_WIDTH)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .mv_en   (do_move),
        .mv_dst  (dst_phys),
        .mv_src  (src_phys),
        .ld_en   (ld_en),
        .ld_slot (ld_slot),
        .ld_data (ld_data),
        .rd_slot (rd_slot),
        .rd_data (rd_data),
        .rd_tag  (rd_tag),
        .tags    (tags)
    );

    // Stack pointer and C1: control write sets them, underflow clears C1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_ptr <= '0;
            c1_flag <= 1'b0;
        end else begin
            if (ctl_wr) begin
                top_ptr <= ctl_top;
                c1_flag <= ctl_c1;
            end
            if (underflow)
                c1_flag <= 1'b0;
        end
    end

    // Registered completion and fault pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done        <= 1'b0;
            moved       <= 1'b0;
            fault_stack <= 1'b0;
            fault_nodev <= 1'b0;
            bad_opcode  <= 1'b0;
        end else begin
            done        <= in_valid;
            moved       <= do_move;
            fault_stack <= underflow;
            fault_nodev <= in_valid & blocked;
            bad_opcode  <= in_valid & ~blocked & ~legal;
        end
    end

    // R9: done follows every accepted instruction.
    a_r9_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> done);
    // R9: at most one fault per instruction.
    a_r9_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fault_stack, fault_nodev, bad_opcode}));
    // R9: outcome outputs only alongside done.
    a_r9_outcome_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        (moved | fault_stack | fault_nodev | bad_opcode) |-> done);
    // R4: an instruction never moves the stack pointer.
    a_r4_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !ctl_wr) |=> $stable(top_ptr));
    // R6: underflow leaves C1 cleared.
    a_r6_c1_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        fault_stack |-> !c1_flag);
    // R7: blocked instruction moves nothing.
    a_r7_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        fault_nodev |-> !moved);
endmodule

// File: tb/fstk_cmov_unit_bench.sv
module fstk_cmov_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [7:0]  op_hi, op_lo;
    logic        flag_cf, flag_zf, flag_pf, ctl_em, ctl_ts;
    logic        ld_en;
    logic [2:0]  ld_slot;
    logic [79:0] ld_data;
    logic        ctl_wr;
    logic [2:0]  ctl_top;
    logic        ctl_c1;
    logic [2:0]  rd_slot;
    logic [79:0] rd_data;
    logic        rd_tag;
    logic [2:0]  top_ptr;
    logic        c1_flag, done, moved, fault_stack, fault_nodev, bad_opcode;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [79:0] m_reg [8];
    logic [7:0]  m_tag;
    logic [2:0]  m_top;
    logic        m_c1;

    always #5 clk = ~clk;

    fstk_cmov_unit u_fstk_cmov_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_hi(op_hi), .op_lo(op_lo),
        .flag_cf(flag_cf), .flag_zf(flag_zf), .flag_pf(flag_pf),
        .ctl_em(ctl_em), .ctl_ts(ctl_ts), .ld_en(ld_en), .ld_slot(ld_slot),
        .ld_data(ld_data), .ctl_wr(ctl_wr), .ctl_top(ctl_top), .ctl_c1(ctl_c1),
        .rd_slot(rd_slot), .rd_data(rd_data), .rd_tag(rd_tag), .top_ptr(top_ptr),
        .c1_flag(c1_flag), .done(done), .moved(moved), .fault_stack(fault_stack),
        .fault_nodev(fault_nodev), .bad_opcode(bad_opcode)
    );

    task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic legal_op(input logic [7:0] hi, input logic [7:0] lo);
        return (hi == 8'hDA || hi == 8'hDB) && (lo >= 8'hC0) && (lo <= 8'hDF);
    endfunction

    function automatic logic cond_of(input logic [7:0] hi, input logic [7:0] lo,
                                     input logic cf, input logic zf, input logic pf);
        logic b;
        case (lo[4:3])
            2'd0: b = cf;
            2'd1: b = zf;
            2'd2: b = cf | zf;
            default: b = pf;
        endcase
        return (hi == 8'hDB) ? !b : b;
    endfunction

    function automatic logic [79:0] rnd80();
        return {$urandom(), $urandom(), 16'($urandom())};
    endfunction

    task automatic idle_inputs();
        in_valid = 0; ld_en = 0; ctl_wr = 0; ctl_em = 0; ctl_ts = 0;
        op_hi = 0; op_lo = 0; flag_cf = 0; flag_zf = 0; flag_pf = 0;
        ld_slot = 0; ld_data = 0; ctl_top = 0; ctl_c1 = 0;
    endtask

    task automatic load(input logic [2:0] slot, input logic [79:0] d);
        ld_en = 1; ld_slot = slot; ld_data = d;
        @(posedge clk); #2;
        ld_en = 0;
        m_reg[slot] = d; m_tag[slot] = 1'b1;
    endtask

    task automatic set_ctl(input logic [2:0] t, input logic c1);
        ctl_wr = 1; ctl_top = t; ctl_c1 = c1;
        @(posedge clk); #2;
        ctl_wr = 0;
        m_top = t; m_c1 = c1;
    endtask

    // Issue one instruction, optionally with a same-cycle load; compare outcome.
    task automatic issue(input string req, input logic [7:0] hi, input logic [7:0] lo,
                         input logic cf, input logic zf, input logic pf,
                         input logic em, input logic ts,
                         input logic lde, input logic [2:0] lds, input logic [79:0] ldd);
        logic e_nodev, e_bad, e_uf, e_mv, c;
        logic [2:0] d, s;
        e_nodev = 0; e_bad = 0; e_uf = 0; e_mv = 0;
        d = m_top; s = m_top + lo[2:0];
        c = cond_of(hi, lo, cf, zf, pf);
        if (em || ts) e_nodev = 1;
        else if (!legal_op(hi, lo)) e_bad = 1;
        else if (!m_tag[d] || (c && !m_tag[s])) e_uf = 1;
        else if (c) e_mv = 1;
        in_valid = 1; op_hi = hi; op_lo = lo; flag_cf = cf; flag_zf = zf; flag_pf = pf;
        ctl_em = em; ctl_ts = ts; ld_en = lde; ld_slot = lds; ld_data = ldd;
        @(posedge clk); #2;
        in_valid = 0; ld_en = 0; ctl_em = 0; ctl_ts = 0;
        if (e_mv) begin m_reg[d] = m_reg[s]; m_tag[d] = 1'b1; end
        if (lde && !(e_mv && lds == d)) begin m_reg[lds] = ldd; m_tag[lds] = 1'b1; end
        if (e_uf) m_c1 = 1'b0;
        rd_slot = d;
        #1;
        chk({req, " done"}, 80'(done), 80'(1'b1));
        chk({req, " moved"}, 80'(moved), 80'(e_mv));
        chk({req, " fault_stack"}, 80'(fault_stack), 80'(e_uf));
        chk({req, " fault_nodev"}, 80'(fault_nodev), 80'(e_nodev));
        chk({req, " bad_opcode"}, 80'(bad_opcode), 80'(e_bad));
        chk({req, " top"}, 80'(top_ptr), 80'(m_top));
        chk({req, " c1"}, 80'(c1_flag), 80'(m_c1));
        chk({req, " st0 tag"}, 80'(rd_tag), 80'(m_tag[d]));
        if (m_tag[d]) chk({req, " st0 data"}, rd_data, m_reg[d]);
        if (lde) begin
            rd_slot = lds; #1;
            chk({req, " load slot"}, rd_data, m_reg[lds]);
        end
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog expired actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle_inputs();
        rd_slot = 0;
        rst_n = 0;
        m_tag = '0; m_top = 0; m_c1 = 0;
        for (int k = 0; k < 8; k++) m_reg[k] = '0;
        repeat (3) @(posedge clk);
        #2; rst_n = 1;
        #1;
        // R1: reset state
        for (int k = 0; k < 8; k++) begin
            rd_slot = 3'(k); #1;
            chk("R1 tag empty", 80'(rd_tag), 80'(1'b0));
        end
        chk("R1 top", 80'(top_ptr), 80'(0));
        chk("R1 c1", 80'(c1_flag), 80'(0));
        chk("R1 done", 80'(done), 80'(0));
        chk("R1 faults", 80'({moved, fault_stack, fault_nodev, bad_opcode}), 80'(0));

        // R6: underflow on empty stack clears C1
        set_ctl(3'd0, 1'b1);
        issue("R6 empty st0", 8'hDA, 8'hC1, 1, 0, 0, 0, 0, 0, 0, '0);
        load(3'd0, rnd80());
        set_ctl(3'd0, 1'b1);
        issue("R6 false cond empty sti", 8'hDA, 8'hC3, 0, 0, 0, 0, 0, 0, 0, '0);
        issue("R6 true cond empty sti", 8'hDA, 8'hC3, 1, 0, 0, 0, 0, 0, 0, '0);

        for (int k = 1; k < 8; k++) load(3'(k), rnd80());
        // R2: direct conditions
        issue("R2 carry", 8'hDA, 8'hC1, 1, 0, 0, 0, 0, 0, 0, '0);
        issue("R2 zero false", 8'hDA, 8'hCA, 1, 0, 1, 0, 0, 0, 0, '0);
        issue("R2 zero", 8'hDA, 8'hCA, 0, 1, 0, 0, 0, 0, 0, '0);
        issue("R2 cz", 8'hDA, 8'hD4, 0, 1, 0, 0, 0, 0, 0, '0);
        issue("R2 parity", 8'hDA, 8'hDD, 0, 0, 1, 0, 0, 0, 0, '0);
        // R5: false condition leaves ST(0)
        issue("R5 false", 8'hDA, 8'hDE, 1, 1, 0, 0, 0, 0, 0, '0);
        // R3: inverse conditions
        issue("R3 ncarry", 8'hDB, 8'hC2, 0, 1, 1, 0, 0, 0, 0, '0);
        issue("R3 ncz false", 8'hDB, 8'hD3, 0, 1, 0, 0, 0, 0, 0, '0);
        issue("R3 ncz", 8'hDB, 8'hD3, 0, 0, 1, 0, 0, 0, 0, '0);
        issue("R3 nparity", 8'hDB, 8'hDF, 1, 1, 0, 0, 0, 0, 0, '0);
        // R4: wrap of source index
        set_ctl(3'd5, 1'b1);
        issue("R4 wrap", 8'hDB, 8'hC3, 0, 0, 0, 0, 0, 0, 0, '0);
        issue("R4 self", 8'hDA, 8'hC0, 1, 0, 0, 0, 0, 0, 0, '0);
        // R7: device not available
        issue("R7 em", 8'hDA, 8'hC1, 1, 0, 0, 1, 0, 0, 0, '0);
        issue("R7 ts", 8'hD9, 8'h00, 1, 0, 0, 0, 1, 0, 0, '0);
        // R8: illegal encodings
        issue("R8 prefix", 8'hD9, 8'hC1, 1, 0, 0, 0, 0, 0, 0, '0);
        issue("R8 high opnd", 8'hDA, 8'hE1, 1, 0, 0, 0, 0, 0, 0, '0);
        issue("R8 low opnd", 8'hDB, 8'hBF, 0, 0, 0, 0, 0, 0, 0, '0);
        // R9: done drops after one cycle
        @(posedge clk); #3;
        chk("R9 done pulse", 80'(done), 80'(0));
        // R10: concurrent load into destination, move wins
        issue("R10 dst collision", 8'hDA, 8'hC2, 1, 0, 0, 0, 0, 1, 3'd5, rnd80());
        // R10: load into empty source same cycle still underflows
        rst_n = 0; @(posedge clk); #2; rst_n = 1;
        m_tag = '0; m_top = 0; m_c1 = 0;
        load(3'd0, rnd80());
        issue("R10 src preload", 8'hDA, 8'hC4, 1, 0, 0, 0, 0, 1, 3'd4, rnd80());
        issue("R10 after load", 8'hDA, 8'hC4, 1, 0, 0, 0, 0, 0, 0, '0);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [7:0] hi, lo;
            int r;
            r = $urandom_range(0, 19);
            hi = (r == 0) ? 8'($urandom()) : ((r < 10) ? 8'hDA : 8'hDB);
            lo = ($urandom_range(0, 15) == 0) ? 8'($urandom()) : (8'hC0 | 8'($urandom_range(0, 31)));
            if ($urandom_range(0, 9) == 0) set_ctl(3'($urandom()), 1'($urandom()));
            issue("R2 R3 R6 random", hi, lo, 1'($urandom()), 1'($urandom()), 1'($urandom()),
                  ($urandom_range(0, 15) == 0), ($urandom_range(0, 15) == 0),
                  ($urandom_range(0, 3) == 0), 3'($urandom()), rnd80());
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule